// File: doc/BRIEF.md
# Output-Compare Pin Action Unit

This block drives eight output pins from a 16-bit free-running timer. Every channel keeps a 16-bit compare value and a 2-bit action code. On a timer tick where the counter equals a channel's compare value, the channel raises its flag and applies its action to its pin. An action can toggle the pin, drive it low or drive it high. Code 00 leaves the pin alone. Each flag can be routed to a shared interrupt request through an enable mask.

Software can also push any channel's pin action out without waiting for a match. It does this by writing a one to that channel's bit in a write-only force register. The forced action is held until the next timer tick and lands on that tick. It moves only the pin: no flag is set and no interrupt is raised.

The register bus is a single-cycle write port with a combinational read port. The timer advances on a clock-enable tick supplied from outside.

Top module: `ocu_top`

## Requirements
- R1: After reset all pins are low, and every flag, compare value, action code, enable bit and the counter read zero.
- R2: The counter, readable at address 13, increases by one on every cycle with `tick_i` high and holds otherwise.
- R3: On a tick where the counter equals a channel's compare value (address n holds the 16-bit compare of channel n, n = 0..7), that channel's flag sets and its pin action is applied at that same clock edge.
- R4: Action code 01 toggles the pin, 10 drives it low, 11 drives it high, and 00 leaves the pin unchanged for both a match and a force.
- R5: Address 8 holds the codes of channels 7..4 with channel 7 in bits [7:6] and channel 4 in bits [1:0]; address 9 holds channels 3..0 in the same order.
- R6: Writing 1 to bit n of the force register (address 10) applies channel n's action at the next tick after the write, and the pin does not move before that tick.
- R7: A forced action sets no flag and raises no interrupt.
- R8: A read of the force register always returns zero.
- R9: `irq_o` is high exactly when some flag is set whose enable bit (address 11, bit n for channel n) is set.
- R10: Flags (address 12) are cleared by writing 1 to their bit; writing 0 leaves them; a match in the same cycle as a clearing write leaves the flag set.
- R11: When a force and a match hit one channel on the same tick, the action is applied once and the flag still sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer clock enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| pin_o | output | 8 | Compare output pins |
| flag_o | output | 8 | Channel compare flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Every channel is first preset high and then preset low. From each level it is forced with all four action codes. This separates toggling from driving and catches a disconnected code that still moves the pin. The same code sweep is repeated through real counter matches, so the match path can be told apart from the force path by the flag and the interrupt. Mixed settings of the two action-code registers check the bit layout. Coinciding force and match, and a clear that lands on the same edge as a set, exercise the ordering rules.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int NCH  = 8;
  localparam int AW   = 4;

  typedef enum logic [1:0] {
    ACT_OFF  = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;

  localparam logic [AW-1:0] A_ACT_HI = 4'd8;
  localparam logic [AW-1:0] A_ACT_LO = 4'd9;
  localparam logic [AW-1:0] A_FORCE  = 4'd10;
  localparam logic [AW-1:0] A_IEN    = 4'd11;
  localparam logic [AW-1:0] A_FLAG   = 4'd12;
  localparam logic [AW-1:0] A_CNT    = 4'd13;
endpackage

// File: rtl/ocu_rst_sync.sv
module ocu_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/ocu_counter.sv
module ocu_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (tick) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  // R2: one step per tick
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == CW'($past(cnt_q) + 1'b1));
  // R2: no step without tick
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/ocu_regs.sv
module ocu_regs
  import ocu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  input  logic [NCH-1:0]          match,
  input  logic [CW-1:0]           cnt,
  output logic [CW-1:0]           rdata,
  output logic [NCH-1:0][CW-1:0]  cmp_o,
  output logic [2*NCH-1:0]        act_o,
  output logic [NCH-1:0]          pend_o,
  output logic [NCH-1:0]          flag_o,
  output logic                    irq_o
);
  localparam int HALF = NCH;  // bits per action register

  logic [NCH-1:0][CW-1:0] cmp_q, cmp_n;
  logic [2*NCH-1:0]       act_q, act_n;
  logic [NCH-1:0]         ien_q, ien_n;
  logic [NCH-1:0]         flag_q, flag_n;
  logic [NCH-1:0]         pend_q, pend_n;
  logic [NCH-1:0]         clr_mask, frc_mask;

  always_comb begin
    cmp_n = cmp_q;
    act_n = act_q;
    ien_n = ien_q;
    clr_mask = '0;
    frc_mask = '0;
    if (wr) begin
      if (!addr[AW-1]) cmp_n[addr[AW-2:0]] = wdata;
      if (addr == A_ACT_HI) act_n[2*NCH-1 -: HALF] = wdata[HALF-1:0];
      if (addr == A_ACT_LO) act_n[HALF-1:0]        = wdata[HALF-1:0];
      if (addr == A_IEN)    ien_n                  = wdata[NCH-1:0];
      if (addr == A_FLAG)   clr_mask               = wdata[NCH-1:0];
      if (addr == A_FORCE)  frc_mask               = wdata[NCH-1:0];
    end
    flag_n = (flag_q & ~clr_mask) | match;
    pend_n = (tick ? '0 : pend_q) | frc_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      act_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
      pend_q <= '0;
    end else begin
      cmp_q  <= cmp_n;
      act_q  <= act_n;
      ien_q  <= ien_n;
      flag_q <= flag_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr[AW-1]) rdata = cmp_q[addr[AW-2:0]];
    else begin
      case (addr)
        A_ACT_HI: rdata[HALF-1:0] = act_q[2*NCH-1 -: HALF];
        A_ACT_LO: rdata[HALF-1:0] = act_q[HALF-1:0];
        A_IEN:    rdata[NCH-1:0]  = ien_q;
        A_FLAG:   rdata[NCH-1:0]  = flag_q;
        A_CNT:    rdata           = cnt;
        default:  rdata           = '0;
      endcase
    end
  end

  assign cmp_o  = cmp_q;
  assign act_o  = act_q;
  assign pend_o = pend_q;
  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ien_q);

  // R7: a flag can only rise after a compare match
  a_r7_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & ~$past(match)) == '0));
  // R9: request implies some flag
  a_r9_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));
  // R10: a match leaves its flag set whatever was written
  a_r10_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |=> ((flag_q & $past(match)) == $past(match)));
  // R8: force register reads back as zero
  a_r8_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_FORCE) |-> (rdata == '0));
endmodule

// File: rtl/ocu_chan.sv
module ocu_chan
  import ocu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic [1:0]    act,
  input  logic          force_req,
  output logic          match_o,
  output logic          pin_o
);
  logic pin_q, pin_n, fire;

  assign match_o = tick && (cnt == cmp);
  assign fire    = tick && ((cnt == cmp) || force_req);

  always_comb begin
    pin_n = pin_q;
    if (fire) begin
      case (act_e'(act))
        ACT_TOG:  pin_n = ~pin_q;
        ACT_LOW:  pin_n = 1'b0;
        ACT_HIGH: pin_n = 1'b1;
        default:  pin_n = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_n;
  end

  assign pin_o = pin_q;

  // R4: disconnected code keeps the pin
  a_r4_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (act == 2'b00) |=> $stable(pin_q));
  // R6: the pin only moves on a tick
  a_r6_pin_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin_q));
  // R11: toggle with force and match together flips exactly once
  a_r11_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && force_req && match_o && act == 2'b01) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/ocu_top.sv
module ocu_top
  import ocu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           tick_i,
  input  logic           bus_wr_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [CW-1:0]  bus_wdata_i,
  output logic [CW-1:0]  bus_rdata_o,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] flag_o,
  output logic           irq_o
);
  logic                   rst_n;
  logic [CW-1:0]          cnt;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [2*NCH-1:0]       act;
  logic [NCH-1:0]         pend;
  logic [NCH-1:0]         match;

  ocu_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  ocu_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_i),
    .cnt_o (cnt)
  );

  ocu_regs #(.CW(CW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .wr     (bus_wr_i),
    .addr   (bus_addr_i),
    .wdata  (bus_wdata_i),
    .match  (match),
    .cnt    (cnt),
    .rdata  (bus_rdata_o),
    .cmp_o  (cmp),
    .act_o  (act),
    .pend_o (pend),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ocu_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_i),
      .cnt       (cnt),
      .cmp       (cmp[g]),
      .act       (act[2*g +: 2]),
      .force_req (pend[g]),
      .match_o   (match[g]),
      .pin_o     (pin_o[g])
    );
  end
endmodule

// File: tb/ocu_top_tb.sv
module ocu_top_tb;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        tick_i;
  logic        bus_wr_i;
  logic [3:0]  bus_addr_i;
  logic [15:0] bus_wdata_i;
  logic [15:0] bus_rdata_o;
  logic [7:0]  pin_o, flag_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] cnt_m = '0;
  logic [7:0]  pins_m = '0;

  always #10 clk = ~clk;

  ocu_top u_dut (
    .clk(clk), .arst_n(arst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  function automatic logic apply(input logic [1:0] code, input logic p);
    case (code)
      2'b01:   return ~p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    cnt_m = cnt_m + 1'b1;
  endtask

  task automatic set_codes(input logic [15:0] codes);
    wr(4'd8, {8'h00, codes[15:8]});
    wr(4'd9, {8'h00, codes[7:0]});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] r;
    arst_n = 1'b0; tick_i = 1'b0; bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pins", {8'h0, pin_o}, 16'h0);
    chk("R1 flags", {8'h0, flag_o}, 16'h0);
    chk("R1 irq", {15'h0, irq_o}, 16'h0);
    rd(4'd0, r);  chk("R1 cmp0", r, 16'h0);
    rd(4'd8, r);  chk("R1 act", r, 16'h0);
    rd(4'd11, r); chk("R1 ien", r, 16'h0);
    rd(4'd13, r); chk("R1 cnt", r, 16'h0);

    for (int i = 0; i < 8; i++) wr(4'(i), 16'hFFFF);
    rd(4'd5, r); chk("R3 cmp readback", r, 16'hFFFF);
    wr(4'd11, 16'h00FF);

    // R5 layout example: 0xD6 / 0x6E then force 0x7F
    wr(4'd8, 16'h00D6);
    wr(4'd9, 16'h006E);
    wr(4'd10, 16'h007F);
    rd(4'd10, r); chk("R8 force reads zero", r, 16'h0);
    chk("R6 no move before tick", {8'h0, pin_o}, 16'h0);
    tick();
    pins_m = 8'h6A;
    chk("R5 example pins", {8'h0, pin_o}, {8'h0, pins_m});
    chk("R7 example flags", {8'h0, flag_o}, 16'h0);
    chk("R7 example irq", {15'h0, irq_o}, 16'h0);

    // R4 force sweep: every channel, both start levels, every code
    for (int ch = 0; ch < 8; ch++) begin
      for (int init = 0; init < 2; init++) begin
        for (int code = 0; code < 4; code++) begin
          set_codes(16'(init ? 3 : 2) << (2 * ch));
          wr(4'd10, 16'(1 << ch));
          tick();
          pins_m[ch] = init[0];
          chk("R4 preset", {8'h0, pin_o}, {8'h0, pins_m});
          set_codes(16'(code) << (2 * ch));
          wr(4'd10, 16'(1 << ch));
          chk("R6 held until tick", {8'h0, pin_o}, {8'h0, pins_m});
          tick();
          pins_m[ch] = apply(2'(code), pins_m[ch]);
          chk("R4 forced action", {8'h0, pin_o}, {8'h0, pins_m});
          chk("R7 no flag", {8'h0, flag_o}, 16'h0);
        end
      end
    end
    chk("R7 no irq after sweep", {15'h0, irq_o}, 16'h0);

    // R3 match sweep with flag clear behaviour
    for (int ch = 0; ch < 8; ch++) begin
      for (int code = 0; code < 4; code++) begin
        set_codes(16'(code) << (2 * ch));
        wr(4'(ch), cnt_m);
        tick();
        pins_m[ch] = apply(2'(code), pins_m[ch]);
        chk("R3 match pin", {8'h0, pin_o}, {8'h0, pins_m});
        chk("R3 match flag", {8'h0, flag_o}, 16'(1 << ch));
        chk("R9 irq on", {15'h0, irq_o}, 16'h1);
        wr(4'(ch), 16'hFFFF);
        wr(4'd12, 16'h0000);
        chk("R10 write 0 keeps", {8'h0, flag_o}, 16'(1 << ch));
        wr(4'd12, 16'(1 << ch));
        chk("R10 write 1 clears", {8'h0, flag_o}, 16'h0);
      end
    end

    // R2 counter matches tick count
    rd(4'd13, r); chk("R2 counter", r, cnt_m);
    repeat (5) @(negedge clk);
    rd(4'd13, r); chk("R2 counter holds", r, cnt_m);

    // R9 enable masking
    wr(4'd11, 16'h0000);
    set_codes(16'h0040);
    wr(4'd3, cnt_m);
    tick();
    pins_m[3] = ~pins_m[3];
    chk("R9 flag without enable", {8'h0, flag_o}, 16'h0008);
    chk("R9 irq masked", {15'h0, irq_o}, 16'h0);
    wr(4'd11, 16'h0008);
    chk("R9 irq enabled", {15'h0, irq_o}, 16'h1);
    wr(4'd3, 16'hFFFF);
    wr(4'd12, 16'h0008);
    wr(4'd11, 16'h00FF);

    // R11 force and match on the same tick
    set_codes(16'h0010);
    wr(4'd2, cnt_m);
    wr(4'd10, 16'h0004);
    tick();
    pins_m[2] = ~pins_m[2];
    chk("R11 single toggle", {8'h0, pin_o}, {8'h0, pins_m});
    chk("R11 flag set", {8'h0, flag_o}, 16'h0004);
    wr(4'd2, 16'hFFFF);
    wr(4'd12, 16'h0004);

    // R10 set wins over a clear in the same cycle
    set_codes(16'h0C00);
    wr(4'd5, cnt_m);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = 4'd12; bus_wdata_i = 16'h0020; tick_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0; tick_i = 1'b0;
    cnt_m = cnt_m + 1'b1;
    pins_m[5] = 1'b1;
    chk("R10 set wins", {8'h0, flag_o}, 16'h0020);
    chk("R3 pin high", {8'h0, pin_o}, {8'h0, pins_m});
    rd(4'd13, r); chk("R2 final counter", r, cnt_m);

    summary();
  end
endmodule